// File: doc/BRIEF.md
# Serial switch-status slave port

This block is a serial-peripheral slave that lets a host read a snapshot of 22 switch inputs plus an interrupt flag, and at the same time load a 24-bit command word. The block runs on a fast system clock. The host signals SCLK, CS (active low) and SI are oversampled in that clock. Their edges are found in the system clock domain.

When CS falls, the block freezes a status word and enables its serial output. Each SCLK rising edge moves the next status bit onto SO, most significant bit first. Each SCLK falling edge shifts one SI bit into a receive register, also most significant bit first. When CS rises, the output is disabled. The received word is copied to the command output, but only if exactly 24 bits were clocked in. SO comes with a separate enable, so that a tri-state pad can be built outside the block.

Top module: `spi_switch_slave`

## Requirements
- R1: After synchronous reset, `so_en` is 0, `so` is 0 and `cmd_out` is all zeros.
- R2: `so_en` goes to 1 after CS falls and returns to 0 after CS rises. While `so_en` is 0, `so` is 0.
- R3: The status word is sampled in the cycle the CS fall is detected, and later input changes do not alter it. Its layout is: bit 23 is `irq_in`, bit 22 is always 0, and bits 21..0 are `sw_in[21:0]`, where 1 means closed and 0 means open.
- R4: The k-th SCLK rising edge after CS falls (k = 1..24) places status bit 24-k on `so`. Before the first rising edge, `so` carries no status bit.
- R5: SI is captured on each SCLK falling edge, most significant bit first. When CS rises after exactly 24 falling edges, `cmd_out` takes the received word.
- R6: When CS rises after any number of SCLK falling edges other than 24 (for example 16 or 25), `cmd_out` keeps its previous value.
- R7: `cmd_out` changes only in response to a CS rise.
- R8: While CS is high, SCLK and SI toggling has no effect: `cmd_out` is unchanged, and `so_en` and `so` stay 0.
- R9: Each pin passes through a two-stage synchronizer. `so_en` becomes 1 on the third system clock rising edge after CS goes low, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Chip select from the host, active low |
| si | input | 1 | Serial data from the host |
| sw_in | input | 22 | Debounced switch states, 1 = closed |
| irq_in | input | 1 | Interrupt flag, latched into status bit 23 |
| so | output | 1 | Serial status data to the host |
| so_en | output | 1 | Output enable for the SO pad driver |
| cmd_out | output | 24 | Last fully received command word |

## Verification
Transfers are run with several status patterns: alternating bits, all closed, all open, and with the interrupt flag set and clear. Together these separate a correct bit order and field placement from a shifted, reversed or mis-placed field. One transfer changes the switches while CS is low, which separates a snapshot taken at the CS fall from a live read. Transfers of 16, 24 and 25 bits, and SCLK toggling with CS high, separate the exact-count commit rule from a commit on every CS rise or from counting while the block is deselected. A cycle-exact check on the CS fall separates the two-stage synchronizer latency from a shorter or longer path.

// File: rtl/spi_sw_pkg.sv
package spi_sw_pkg;
  // decoded view of one synchronised host pin
  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } pin_evt_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output spi_sw_pkg::pin_evt_t evt [W]
);
  logic [W-1:0] chain [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RST_VAL;
    else     chain[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= RST_VAL;
      else     chain[s] <= chain[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= chain[STAGES-1];
  end

  for (genvar b = 0; b < W; b++) begin : g_evt
    assign evt[b].lvl  = chain[STAGES-1][b];
    assign evt[b].rise = chain[STAGES-1][b] & ~prev[b];
    assign evt[b].fall = ~chain[STAGES-1][b] & prev[b];
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_lvl,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              si_lvl,
  input  logic [WORD_W-1:0] status_in,
  output logic              so,
  output logic              so_en,
  output logic [WORD_W-1:0] cmd
);
  localparam int CW = $clog2(WORD_W + 2);
  localparam logic [CW-1:0] FULL = CW'(WORD_W);
  localparam logic [CW-1:0] SAT  = CW'(WORD_W + 1);

  logic [WORD_W-1:0] tx_sr, rx_sr;
  logic [CW-1:0]     cnt;
  logic              active;

  assign active = ~cs_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr <= '0;
      rx_sr <= '0;
      cnt   <= '0;
      so    <= 1'b0;
      so_en <= 1'b0;
      cmd   <= '0;
    end else if (cs_fall) begin
      tx_sr <= status_in;
      cnt   <= '0;
      so    <= 1'b0;
      so_en <= 1'b1;
    end else if (cs_rise) begin
      so    <= 1'b0;
      so_en <= 1'b0;
      if (cnt == FULL) cmd <= rx_sr;
    end else if (active) begin
      if (sclk_rise) begin
        so    <= tx_sr[WORD_W-1];
        tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
      end
      if (sclk_fall) begin
        rx_sr <= {rx_sr[WORD_W-2:0], si_lvl};
        if (cnt != SAT) cnt <= cnt + 1'b1;
      end
    end
  end

  // R2: the enable only rises because a CS fall was seen
  p_en_from_fall_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(so_en) |-> $past(cs_fall));
  // R2: data line is quiet while the driver is off
  p_so_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !so_en |-> !so);
  // R6: a CS rise with the wrong bit count keeps the command
  p_short_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && cnt != FULL) |=> $stable(cmd));
  // R7: the command moves only after a CS rise
  p_cmd_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !cs_rise |=> $stable(cmd));
  // R8: deselected, the receive side does not move
  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (cs_lvl && !cs_fall) |=> ($stable(rx_sr) && $stable(cnt)));
  // R5: the counter saturates above a full word
  always_comb begin
    if (!rst) p_cnt_bound_r5: assert (cnt <= SAT);
  end
endmodule

// File: rtl/spi_switch_slave.sv
module spi_switch_slave #(
  parameter int WORD_W = 24,
  parameter int SW_N   = 22,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              si,
  input  logic [SW_N-1:0]   sw_in,
  input  logic              irq_in,
  output logic              so,
  output logic              so_en,
  output logic [WORD_W-1:0] cmd_out
);
  import spi_sw_pkg::*;

  localparam int PIN_SCLK = 0;
  localparam int PIN_CS   = 1;
  localparam int PIN_SI   = 2;

  pin_evt_t          evt [3];
  logic [WORD_W-1:0] status_w;

  always_comb begin
    status_w = '0;
    status_w[SW_N-1:0]  = sw_in;
    status_w[WORD_W-1]  = irq_in;
  end

  spi_pin_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(3'b010)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({si, cs_n, sclk}),
    .evt (evt)
  );

  spi_shift_core #(.WORD_W(WORD_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .cs_lvl    (evt[PIN_CS].lvl),
    .cs_fall   (evt[PIN_CS].fall),
    .cs_rise   (evt[PIN_CS].rise),
    .sclk_rise (evt[PIN_SCLK].rise),
    .sclk_fall (evt[PIN_SCLK].fall),
    .si_lvl    (evt[PIN_SI].lvl),
    .status_in (status_w),
    .so        (so),
    .so_en     (so_en),
    .cmd       (cmd_out)
  );

  // R3: switch field has room below the flag bit
  initial p_layout_fit_r3: assert (SW_N <= WORD_W - 2);
endmodule

// File: tb/spi_switch_slave_tb.sv
module spi_switch_slave_tb;
  localparam int W = 24;
  localparam int N = 22;
  localparam int HALF = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, si = 1'b0, irq_in = 1'b0;
  logic [N-1:0] sw_in = '0;
  logic so, so_en;
  logic [W-1:0] cmd_out;

  int vectors = 0, errors = 0;
  logic [W-1:0] exp_cmd = '0;
  bit mon_on = 0;

  always #2 clk = ~clk;

  spi_switch_slave u_dut (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .si(si),
    .sw_in(sw_in), .irq_in(irq_in), .so(so), .so_en(so_en), .cmd_out(cmd_out)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // per-clock reference check of the command register (R7)
  always @(negedge clk) begin
    if (mon_on) chk("R7 cmd_out", 32'(cmd_out), 32'(exp_cmd));
  end

  // one transfer of nbits; optional switch change mid-transfer
  task automatic xfer(int nbits, logic [W-1:0] word, bit flip_sw);
    logic [W-1:0] exp_st;
    exp_st = {irq_in, 1'b0, sw_in};
    @(posedge clk); #1 cs_n = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R9 so_en early", 32'(so_en), 0);
    @(posedge clk); @(negedge clk);
    chk("R9 so_en on third edge", 32'(so_en), 1);
    wait_clk(HALF);
    chk("R2 so_en while selected", 32'(so_en), 1);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b1;
      si = (i < W) ? word[W-1-i] : 1'b0;
      wait_clk(HALF);
      if (i < W) chk($sformatf("R4 R3 status bit %0d", W-1-i), 32'(so), 32'(exp_st[W-1-i]));
      if (flip_sw && i == 3) begin
        sw_in = ~sw_in; irq_in = ~irq_in;
      end
      sclk = 1'b0;
      wait_clk(HALF);
    end
    mon_on = 0;
    cs_n = 1'b1;
    wait_clk(HALF);
    chk("R2 so_en after CS rise", 32'(so_en), 0);
    chk("R2 so quiet", 32'(so), 0);
    if (nbits == W) exp_cmd = word;
    chk(nbits == W ? "R5 command committed" : "R6 command kept", 32'(cmd_out), 32'(exp_cmd));
    mon_on = 1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_clk(4);
    rst = 1'b0;
    wait_clk(1);
    chk("R1 so_en", 32'(so_en), 0);
    chk("R1 so", 32'(so), 0);
    chk("R1 cmd_out", 32'(cmd_out), 0);
    mon_on = 1;

    sw_in = 22'h2AAAAA; irq_in = 1'b1;
    xfer(W, 24'hA5C3F0, 0);
    sw_in = '1; irq_in = 1'b0;
    xfer(W, 24'h123456, 0);
    sw_in = '0; irq_in = 1'b1;
    xfer(W, 24'hFFFFFF, 0);
    sw_in = 22'h0F0F33; irq_in = 1'b0;
    xfer(W, 24'h800001, 1);   // R3 snapshot held despite change
    xfer(16, 24'hDEADBE, 0);  // R6 short
    xfer(25, 24'h0BADC0, 0);  // R6 long

    // R8: activity while deselected
    for (int i = 0; i < 30; i++) begin
      sclk = ~sclk; si = i[1];
      wait_clk(HALF);
      chk("R8 so_en idle", 32'(so_en), 0);
      chk("R8 so idle", 32'(so), 0);
    end
    sclk = 1'b0;
    wait_clk(HALF);
    chk("R8 cmd_out idle", 32'(cmd_out), 32'(exp_cmd));

    sw_in = 22'h155555; irq_in = 1'b1;
    xfer(W, 24'h5A5A5A, 0);
    wait_clk(4);
    finish_run();
  end
endmodule